// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Request Unit

This block keeps the four event flags of one timer/counter channel group: the capture flag, two compare-match flags (channels A and B) and the overflow flag. The counter, the waveform generator and the output pins sit outside the block. Their state reaches it as inputs: the counter value, the two compare values, the capture strobe, a TOP-reached indication, a one-cycle timer tick and a waveform mode code. Each flag is set by its own rule. Software or the interrupt controller clears it. Each flag drives an interrupt request through a mask bit.

Software reaches the block through a write-only bus port with two targets. Address 0 is the flag register, which clears on a write of one. Address 1 is the mask register. When the interrupt controller services a vector, it pulses that flag's acknowledge input for one cycle, and this clears the flag. A set event that lands in the same cycle as any clear always wins.

The block also gives the waveform generator a compare-event strobe per channel. The strobe pulses for a real match on a tick and also for a forced-compare request. The flags never react to the forced request.

Top module: `tmr_flag_unit`

## Requirements
- R1: When the mode is not a capture-as-TOP mode (codes 0, 1, 3, 5, 6, 7), a high `cap_strobe_i` sets the capture flag (register bit 5) at the next clock edge, whether or not a tick is present. `at_top_i` has no effect in these modes.
- R2: In capture-as-TOP modes (code 2, clear-on-match with the capture value as TOP, and code 4, PWM with the capture value as TOP), the capture flag sets on a tick cycle with `at_top_i` high. `cap_strobe_i` is ignored in these modes, and so is `at_top_i` without a tick.
- R3: Compare flag A (bit 4) and compare flag B (bit 3) set on the first tick after a tick on which `cnt_i` equalled that channel's compare value. An equality on a cycle without a tick arms nothing.
- R4: `force_i` (bit 0 for A, bit 1 for B) never sets a compare flag. `cmp_evt_o` pulses in the same cycle for a forced request or for a tick with a match.
- R5: In modes 0 (Normal), 1 and 2 (clear-on-match) and the reserved modes 5 to 7, the overflow flag (bit 2) sets on a tick with `cnt_i` at its all-ones maximum.
- R6: In PWM modes 3 and 4, the overflow flag sets on a tick with `cnt_i` equal to zero, and not at the maximum.
- R7: A write to address 0 (`wr_sel_i`=0) clears every flag whose bit is 1 in `wr_data_i`. Zero bits and the reserved bits 7, 6, 1 and 0 change nothing.
- R8: A pulse on `ack_i` clears one flag. The bits map as 3 to capture, 2 to compare A, 1 to compare B and 0 to overflow.
- R9: If a flag's set event coincides with a write-one clear or an acknowledge of that flag, the flag ends up set.
- R10: A write to address 1 loads the mask from `wr_data_i[5:2]` without touching the flags. `irq_o[k]` is flag bit k+2 AND mask bit k+2, with the same order as `ack_i`.
- R11: While `rst_n` is low at a clock edge, the flags, the mask and the armed compare state clear. `flags_o` then reads 0 and `irq_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle timer tick |
| cnt_i | input | CNT_W | Counter value |
| ocr_a_i | input | CNT_W | Compare value, channel A |
| ocr_b_i | input | CNT_W | Compare value, channel B |
| cap_strobe_i | input | 1 | Capture event on the capture pin |
| force_i | input | 2 | Forced-compare request, bit 0 A, bit 1 B |
| mode_i | input | 3 | Waveform mode code |
| at_top_i | input | 1 | Counter is at TOP |
| wr_en_i | input | 1 | Bus write strobe |
| wr_sel_i | input | 1 | Write target: 0 flags, 1 mask |
| wr_data_i | input | 8 | Write data |
| ack_i | input | 4 | Vector acknowledges {cap, A, B, ovf} |
| flags_o | output | 8 | Flag register image |
| irq_o | output | 4 | Interrupt requests {cap, A, B, ovf} |
| cmp_evt_o | output | 2 | Compare event strobes to the waveform generator |

## Verification
The bench sweeps every compare value of a 4-bit counter against every counter value. A design that sets the compare flag in the match cycle itself, or two ticks late, fails at the boundary where the count equals the compare value. Separate runs space the ticks apart and drive an equality on a cycle with no tick. These catch a design that arms on plain clock cycles or that fires on the wrong edge. Forced strobes, the capture-versus-TOP switch and the overflow point in PWM against non-PWM modes are each driven where a wrong choice flips a single flag. Set and clear collide on purpose, to expose a design that loses an event, and the mask is swept over all sixteen values with every flag set.

// File: rtl/tmr_flag_pkg.sv
// Shared constants and mode decoding for the timer flag unit.
// Assumes a flag register with four flags packed at bits 5..2.
package tmr_flag_pkg;
    localparam int REG_W     = 8;
    localparam int FLAG_N    = 4;
    localparam int FLAG_BASE = 2;
    localparam int CH_N      = 2;
    // flag indices inside the packed 4-bit vector (register bit = index + FLAG_BASE)
    localparam int IDX_OVF   = 0;
    localparam int IDX_CMPB  = 1;
    localparam int IDX_CMPA  = 2;
    localparam int IDX_CAP   = 3;

    typedef enum logic [2:0] {
        WM_NORMAL   = 3'd0,
        WM_CLR_OCR  = 3'd1,
        WM_CLR_CAP  = 3'd2,
        WM_PWM_OCR  = 3'd3,
        WM_PWM_CAP  = 3'd4
    } wave_mode_e;

    // capture register acts as TOP in these modes
    function automatic logic mode_cap_top(input logic [2:0] m);
        return (m == WM_CLR_CAP) || (m == WM_PWM_CAP);
    endfunction

    // overflow reported at BOTTOM in these modes
    function automatic logic mode_pwm(input logic [2:0] m);
        return (m == WM_PWM_OCR) || (m == WM_PWM_CAP);
    endfunction
endpackage

// File: rtl/tmr_cmp_unit.sv
// One compare channel: arms on a tick whose count equals the compare
// value and reports a flag-set pulse on the following tick. A forced
// request only reaches the waveform strobe, never the flag path.
// Assumes tick_i is a single-cycle pulse.
module tmr_cmp_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] ocr_i,
    input  logic             force_i,
    output logic             set_o,
    output logic             evt_o
);
    logic match;
    logic armed_q;

    // equality of counter and compare value
    always_comb match = (cnt_i == ocr_i);

    // hold the match seen on the last tick until the next tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (tick_i)
            armed_q <= match;
    end

    // flag set one tick after the match; waveform strobe on match or force
    always_comb begin
        set_o = tick_i && armed_q;
        evt_o = (tick_i && match) || force_i;
    end
endmodule

// File: rtl/tmr_evt_decode.sv
// Decodes the capture and overflow set events from the mode code.
// Capture follows either the pin strobe or a TOP-reached tick; overflow
// fires at the counter maximum or, in PWM modes, at BOTTOM.
module tmr_evt_decode #(
    parameter int CNT_W = 16
) (
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [2:0]       mode_i,
    input  logic             cap_strobe_i,
    input  logic             at_top_i,
    output logic             cap_set_o,
    output logic             ovf_set_o
);
    import tmr_flag_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic cap_top;
    logic pwm;

    // mode classification
    always_comb begin
        cap_top = mode_cap_top(mode_i);
        pwm     = mode_pwm(mode_i);
    end

    // capture source selection
    always_comb cap_set_o = cap_top ? (tick_i && at_top_i) : cap_strobe_i;

    // overflow point selection
    always_comb begin
        if (pwm)
            ovf_set_o = tick_i && (cnt_i == '0);
        else
            ovf_set_o = tick_i && (cnt_i == CNT_MAX);
    end
endmodule

// File: rtl/tmr_flag_reg.sv
// Flag and mask storage. Flags clear on a write of one or on an
// acknowledge; a same-cycle set takes priority. Requests are flags
// gated by the mask.
module tmr_flag_reg #(
    parameter int FLAG_N    = 4,
    parameter int FLAG_BASE = 2,
    parameter int REG_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_i,
    input  logic [FLAG_N-1:0] ack_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [FLAG_N-1:0] wr_bits_i,
    output logic [REG_W-1:0]  flags_o,
    output logic [FLAG_N-1:0] irq_o
);
    localparam int HI_PAD = REG_W - FLAG_N - FLAG_BASE;

    logic [FLAG_N-1:0] flag_q;
    logic [FLAG_N-1:0] mask_q;
    logic [FLAG_N-1:0] clr;

    // clear sources: write-one to the flag address, or acknowledge
    always_comb clr = ack_i | ((wr_en_i && !wr_sel_i) ? wr_bits_i : '0);

    // flag update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~clr) | set_i;
    end

    // mask load from the mask address
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en_i && wr_sel_i)
            mask_q <= wr_bits_i;
    end

    // register image and gated requests
    always_comb begin
        flags_o = {{HI_PAD{1'b0}}, flag_q, {FLAG_BASE{1'b0}}};
        irq_o   = flag_q & mask_q;
    end
endmodule

// File: rtl/tmr_flag_unit.sv
// Top of the timer event flag unit: two compare channels, the
// capture/overflow decoder and the flag/mask register.
// Assumes all inputs are synchronous to clk.
module tmr_flag_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] ocr_a_i,
    input  logic [CNT_W-1:0] ocr_b_i,
    input  logic             cap_strobe_i,
    input  logic [1:0]       force_i,
    input  logic [2:0]       mode_i,
    input  logic             at_top_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [7:0]       wr_data_i,
    input  logic [3:0]       ack_i,
    output logic [7:0]       flags_o,
    output logic [3:0]       irq_o,
    output logic [1:0]       cmp_evt_o
);
    import tmr_flag_pkg::*;

    logic [CNT_W-1:0]  ocr_arr [CH_N];
    logic [CH_N-1:0]   cmp_set;
    logic [FLAG_N-1:0] set_vec;
    logic              cap_set;
    logic              ovf_set;
    logic              unused_wr_bits;

    // bits outside the flag field are ignored on writes
    always_comb unused_wr_bits = ^{wr_data_i[7:6], wr_data_i[1:0]};

    // compare values as an indexed array
    always_comb begin
        ocr_arr[0] = ocr_a_i;
        ocr_arr[1] = ocr_b_i;
    end

    // one compare unit per channel
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_cmp
        tmr_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .cnt_i   (cnt_i),
            .ocr_i   (ocr_arr[ch]),
            .force_i (force_i[ch]),
            .set_o   (cmp_set[ch]),
            .evt_o   (cmp_evt_o[ch])
        );
    end

    tmr_evt_decode #(.CNT_W(CNT_W)) u_dec (
        .tick_i       (tick_i),
        .cnt_i        (cnt_i),
        .mode_i       (mode_i),
        .cap_strobe_i (cap_strobe_i),
        .at_top_i     (at_top_i),
        .cap_set_o    (cap_set),
        .ovf_set_o    (ovf_set)
    );

    // gather set events in register order
    always_comb begin
        set_vec           = '0;
        set_vec[IDX_CAP]  = cap_set;
        set_vec[IDX_CMPA] = cmp_set[0];
        set_vec[IDX_CMPB] = cmp_set[1];
        set_vec[IDX_OVF]  = ovf_set;
    end

    tmr_flag_reg #(.FLAG_N(FLAG_N), .FLAG_BASE(FLAG_BASE), .REG_W(REG_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .ack_i     (ack_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_bits_i (wr_data_i[FLAG_BASE+FLAG_N-1:FLAG_BASE]),
        .flags_o   (flags_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/tmr_flag_unit_chk.sv
// Property checker for tmr_flag_unit, attached by bind below.
module tmr_flag_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [2:0]       mode_i,
    input logic             cap_strobe_i,
    input logic             at_top_i,
    input logic [3:0]       ack_i,
    input logic [3:0]       set_vec,
    input logic [7:0]       flags_o,
    input logic [3:0]       irq_o
);
    import tmr_flag_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_cap_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_strobe_i && !mode_cap_top(mode_i)) |=> flags_o[5]);

    p_cap_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && at_top_i && mode_cap_top(mode_i)) |=> flags_o[5]);

    p_cmp_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags_o[4]) || $rose(flags_o[3])) |-> $past(tick_i));

    p_ovf_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !mode_pwm(mode_i) && cnt_i == CNT_MAX) |=> flags_o[2]);

    p_ovf_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mode_pwm(mode_i) && cnt_i == '0) |=> flags_o[2]);

    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[3] && !set_vec[3]) |=> !flags_o[5]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags_o[5:2] & $past(set_vec)) == $past(set_vec)));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~flags_o[5:2]) == 4'b0);

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (flags_o == 8'h00 && irq_o == 4'h0));
endmodule

bind tmr_flag_unit tmr_flag_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .cnt_i        (cnt_i),
    .mode_i       (mode_i),
    .cap_strobe_i (cap_strobe_i),
    .at_top_i     (at_top_i),
    .ack_i        (ack_i),
    .set_vec      (set_vec),
    .flags_o      (flags_o),
    .irq_o        (irq_o)
);

// File: tb/tmr_flag_unit_bench.sv
module tmr_flag_unit_bench;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick;
    logic [CW-1:0] cnt, ocr_a, ocr_b;
    logic          cap;
    logic [1:0]    frc;
    logic [2:0]    mode;
    logic          at_top;
    logic          wr_en, wr_sel;
    logic [7:0]    wr_data;
    logic [3:0]    ack;
    logic [7:0]    flags;
    logic [3:0]    irq;
    logic [1:0]    evt;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmr_flag_unit #(.CNT_W(CW)) u_tmr_flag_unit (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_i(cnt),
        .ocr_a_i(ocr_a), .ocr_b_i(ocr_b), .cap_strobe_i(cap),
        .force_i(frc), .mode_i(mode), .at_top_i(at_top),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .ack_i(ack), .flags_o(flags), .irq_o(irq), .cmp_evt_o(evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        tick = 0; cap = 0; frc = 0; at_top = 0;
        wr_en = 0; wr_sel = 0; wr_data = 0; ack = 0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 0; wr_sel = 0; wr_data = 0;
    endtask

    // disarm compare channels with a non-matching tick, then clear flags
    task automatic settle(input logic [CW-1:0] safe_cnt);
        tick = 1; cnt = safe_cnt;
        step();
        tick = 0;
        wr(1'b0, 8'hFF);
    endtask

    // set all four flags in mode 0 with ocr_a = ocr_b = 5
    task automatic set_all();
        mode = 3'd0; ocr_a = 5; ocr_b = 5;
        settle(4'd6);
        cap = 1; step(); cap = 0;
        tick = 1; cnt = 5; step();
        cnt = 15; step();
        tick = 0; cnt = 6;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0; cnt = 0; ocr_a = 0; ocr_b = 0; mode = 0;
        repeat (3) @(negedge clk);
        chk("R11 flags in reset", flags, 8'h00);
        chk("R11 irq in reset", irq, 4'h0);
        rst_n = 1;
        step();
        chk("R11 flags after reset", flags, 8'h00);

        // R3/R5: full sweep of compare values against counter values
        mode = 3'd0;
        for (int v = 0; v < 16; v++) begin
            ocr_a = v[CW-1:0];
            ocr_b = CW'((v + 7) % 16);
            settle(CW'(v ^ 1));
            for (int c = 0; c < 16; c++) begin
                logic [7:0] e;
                tick = 1; cnt = c[CW-1:0];
                step();
                e = 8'h00;
                e[4] = (c > v);
                e[3] = (c > ((v + 7) % 16));
                e[2] = (c == 15);
                chk("R3 R5 sweep", flags, e);
            end
            tick = 0;
        end

        // R3: ticks spaced apart, equality without tick arms nothing
        ocr_a = 3; ocr_b = 9;
        settle(4'd5);
        tick = 1; cnt = 3; step();
        chk("R3 no set in match tick", flags, 8'h00);
        tick = 0; step();
        chk("R3 no set without tick", flags, 8'h00);
        cnt = 9; step();
        tick = 1; cnt = 4; step();
        chk("R3 set on next tick only A", flags, 8'h10);
        cnt = 5; step();
        chk("R3 untick match ignored B", flags, 8'h10);
        tick = 0;

        // R4: forced requests
        settle(4'd5);
        frc = 2'b11; tick = 1; cnt = 6;
        #1 chk("R4 force strobe", evt, 2'b11);
        step();
        frc = 0; cnt = 7; step();
        chk("R4 force sets no flag", flags, 8'h00);
        cnt = 3;
        #1 chk("R4 match strobe", evt, 2'b01);
        tick = 0; cnt = 3;
        #1 chk("R4 no strobe without tick", evt, 2'b00);

        // R1/R2: capture source
        ocr_a = 12; ocr_b = 13; mode = 3'd0;
        settle(4'd5);
        cap = 1; step(); cap = 0;
        chk("R1 pin capture", flags, 8'h20);
        wr(1'b0, 8'h20);
        tick = 1; at_top = 1; step(); tick = 0; at_top = 0;
        chk("R1 top ignored in normal", flags, 8'h00);
        for (int m = 2; m <= 4; m += 2) begin
            mode = m[2:0];
            wr(1'b0, 8'hFF);
            cap = 1; step(); cap = 0;
            chk("R2 pin ignored", flags, 8'h00);
            at_top = 1; step();
            chk("R2 top without tick", flags, 8'h00);
            tick = 1; step(); tick = 0; at_top = 0;
            chk("R2 top capture", flags, 8'h20);
        end

        // R5/R6: overflow point per mode
        mode = 3'd3; wr(1'b0, 8'hFF);
        tick = 1; cnt = 15; step();
        chk("R6 no ovf at max in PWM", flags, 8'h00);
        cnt = 0; step(); tick = 0;
        chk("R6 ovf at bottom", flags, 8'h04);
        mode = 3'd0; wr(1'b0, 8'hFF);
        tick = 1; cnt = 0; step(); tick = 0;
        chk("R5 no ovf at bottom normal", flags, 8'h00);
        mode = 3'd1;
        tick = 1; cnt = 15; step(); tick = 0;
        chk("R5 ovf in CTC", flags, 8'h04);
        mode = 3'd0; wr(1'b0, 8'hFF);
        cnt = 15; step();
        chk("R5 no ovf without tick", flags, 8'h00);
        cnt = 5;

        // R9: set beats clear
        cap = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h20; step();
        cap = 0; wr_en = 0; wr_data = 0;
        chk("R9 set beats write", flags, 8'h20);
        cap = 1; ack = 4'b1000; step(); cap = 0; ack = 0;
        chk("R9 set beats ack", flags, 8'h20);
        ack = 4'b1000; step(); ack = 0;
        chk("R8 ack clears cap", flags, 8'h00);
        tick = 1; cnt = 15; wr_en = 1; wr_data = 8'h04; step();
        tick = 0; wr_en = 0; wr_data = 0; cnt = 5;
        chk("R9 ovf beats write", flags, 8'h04);

        // R7: write-one-to-clear
        set_all();
        chk("R7 all set", flags, 8'h3C);
        wr(1'b0, 8'h00);
        chk("R7 zero write", flags, 8'h3C);
        wr(1'b0, 8'hC3);
        chk("R7 reserved bits", flags, 8'h3C);
        wr(1'b0, 8'h10);
        chk("R7 clear A", flags, 8'h2C);
        wr(1'b0, 8'h24);
        chk("R7 clear cap ovf", flags, 8'h08);

        // R8: acknowledges one at a time
        set_all();
        ack = 4'b0100; step(); ack = 0;
        chk("R8 ack A", flags, 8'h2C);
        ack = 4'b0001; step(); ack = 0;
        chk("R8 ack ovf", flags, 8'h28);
        ack = 4'b0010; step(); ack = 0;
        chk("R8 ack B", flags, 8'h20);

        // R10: mask sweep
        set_all();
        for (int m = 0; m < 16; m++) begin
            wr(1'b1, 8'(m << 2));
            chk("R10 irq mask", irq, m[3:0]);
        end
        chk("R10 mask write keeps flags", flags, 8'h3C);
        ack = 4'b1000; step(); ack = 0;
        chk("R10 irq follows flag", irq, 4'b0111);

        // R11: reset mid-run
        rst_n = 0; step(); rst_n = 1; step();
        chk("R11 flags after mid reset", flags, 8'h00);
        set_all();
        chk("R11 mask cleared by reset", irq, 4'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule